// File: doc/BRIEF.md
# Multi-Size Integer Arithmetic Unit

This combinational unit is the integer datapath of a small register-based processor. Each operation takes a destination operand, a second operand, a size select, an operation code, a step code and the current condition flags. In the same cycle it produces the value to write back and the next flag values. Byte, word and longword operations share one 32-bit adder. Each size reads its own carry, overflow and half-carry positions from that adder. A separate byte path corrects a packed-BCD sum or difference into two decimal digits, using the carry and half-carry left by the previous instruction.

Some combinations of operation, size, operand kind and step are not allowed. For these the unit raises `illegal_o`, returns the destination unchanged and passes the incoming flags through unchanged, so decode logic can trap them. Register storage, instruction decode and the flag register all live outside this block.

Top module: `arith_unit`

## Requirements
- R1: Operation codes are: 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-borrow, 4 increment, 5 decrement, 6 long add-constant, 7 long subtract-constant, 8 decimal adjust after add, 9 decimal adjust after subtract. Size codes are: 0 byte, 1 word, 2 long. Add (0) and subtract (1) compute dst+src or dst-src over the low 8, 16 or 32 bits. The flags are flags_o[3]=N (result MSB), [2]=Z (sized result is zero), [1]=V (signed overflow) and [0]=C (carry out on add, borrow on subtract).
- R2: Subtract (1) at byte size with src_imm_i=1 is illegal. Any illegal case drives illegal_o=1, result_o=dst_i and flags_o=flags_i. Legal cases drive illegal_o=0.
- R3: Add-with-carry (2) computes dst+src+flags_i[0]. Subtract-with-borrow (3) computes dst-src-flags_i[0]. Both are legal only at byte size.
- R4: Increment (4) and decrement (5) add or subtract 1 (step code 0) or 2 (step code 1) at any size. At byte size only step code 0 is legal. Step codes 2 and 3 are illegal for these operations.
- R5: Long add-constant (6) and long subtract-constant (7) are legal only at long size. They use step codes 0, 1 and 2 for the values 1, 2 and 4, and return flags_o equal to flags_i.
- R6: Decimal adjust after add (8), byte only, adds 0x06 when the low digit exceeds 9 or H=flags_i[4] is set. It adds 0x60 and sets C when C is set or the byte exceeds 0x99.
- R7: Decimal adjust after subtract (9), byte only, adds 0xFA when H is set and 0xA0 when C is set, and leaves C unchanged. Both adjusts give V=0, keep H, and set N and Z from the byte.
- R8: For byte and word operations, result_o bits above the operand size equal the matching bits of dst_i.
- R9: The half-carry flag flags_o[4] is the carry (on add) or borrow (on subtract) out of bit 3, 11 or 27 for byte, word or long.
- R10: Size code 3, operation codes 10 to 15 and step code 3 for operations 6 and 7 are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| src_imm_i | input | 1 | Second operand comes from an immediate |
| step_i | input | 2 | Step code for increment, decrement and constant ops |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Second operand (register or immediate value) |
| flags_i | input | 5 | Current flags {H,N,Z,V,C} |
| result_o | output | 32 | Value to write back |
| flags_o | output | 5 | Next flags {H,N,Z,V,C} |
| illegal_o | output | 1 | Combination is not allowed |

## Verification
The bench looks for five kinds of errors at the edges of this unit.

- **Flag positions at the wrong size.** Byte and word flags that are taken from the longword position show up as a wrong C, V or H. A word add that carries out of bit 11 only flags this unless H is taken from bit 11.
- **Borrow polarity.** A design that reports the raw adder carry on a subtract gets C and H inverted.
- **Decimal adjust.** The byte 0x9A with both flags clear needs both corrections. A design that tests only the high digit returns 0xA0 instead of 0x00 with carry set. The subtract form must leave C untouched.
- **Illegal combinations.** Byte subtract of an immediate, a byte step of 2 and a word constant add must each raise the illegal flag. A unit that lets any of them through alters the destination or the flags.
- **Upper bits on narrow operations.** A design that zeroes or sign-extends the bits above the operand size corrupts those bits of the destination.

// File: rtl/arith_pkg.sv
package arith_pkg;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned FLAG_W  = 5;
   localparam int unsigned OP_W    = 4;

   localparam int unsigned FLG_C = 0;
   localparam int unsigned FLG_V = 1;
   localparam int unsigned FLG_Z = 2;
   localparam int unsigned FLG_N = 3;
   localparam int unsigned FLG_H = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_ADDC  = 4'd2,
      OP_SUBB  = 4'd3,
      OP_INC   = 4'd4,
      OP_DEC   = 4'd5,
      OP_ADDK  = 4'd6,
      OP_SUBK  = 4'd7,
      OP_DADJA = 4'd8,
      OP_DADJS = 4'd9
   } op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;
endpackage

// File: rtl/arith_legal.sv
module arith_legal
   import arith_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   input  logic [1:0]      size_i,
   input  logic            src_imm_i,
   input  logic [1:0]      step_i,
   output logic            illegal_o
);
   logic is_byte;
   always_comb begin
      is_byte   = (size_i == SZ_BYTE);
      illegal_o = (size_i == SZ_RSVD);
      case (op_i)
         OP_ADD:           ;
         OP_SUB:           if (is_byte && src_imm_i) illegal_o = 1'b1;
         OP_ADDC, OP_SUBB: if (!is_byte) illegal_o = 1'b1;
         OP_INC, OP_DEC:   if (step_i[1] || (is_byte && step_i != 2'd0)) illegal_o = 1'b1;
         OP_ADDK, OP_SUBK: if (size_i != SZ_LONG || step_i == 2'd3) illegal_o = 1'b1;
         OP_DADJA, OP_DADJS: if (!is_byte) illegal_o = 1'b1;
         default:          illegal_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/arith_adder.sv
module arith_adder
   import arith_pkg::*;
#(
   parameter int unsigned WIDTH = DATA_W
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [1:0]        size_i,
   input  logic [1:0]        step_i,
   input  logic [WIDTH-1:0]  dst_i,
   input  logic [WIDTH-1:0]  src_i,
   input  logic              carry_i,
   output logic [WIDTH-1:0]  sum_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam int unsigned IDX_W = $clog2(WIDTH);

   generate
      if (WIDTH != 32) begin : g_width_chk
         $error("arith_adder: WIDTH must be 32");
      end
   endgenerate

   logic             is_sub, use_step;
   logic [WIDTH-1:0] step_val, b_raw, b_eff;
   logic             c_in, c_top;
   logic [WIDTH-1:0] c_into, c_out;
   logic [IDX_W-1:0] msb, hb;
   logic [WIDTH-1:0] size_mask;

   always_comb begin
      is_sub   = (op_i == OP_SUB) || (op_i == OP_SUBB) || (op_i == OP_DEC) || (op_i == OP_SUBK);
      use_step = (op_i == OP_INC) || (op_i == OP_DEC) || (op_i == OP_ADDK) || (op_i == OP_SUBK);
      step_val = WIDTH'(1) << step_i;
      b_raw    = use_step ? step_val : src_i;
      b_eff    = is_sub ? ~b_raw : b_raw;
      if (op_i == OP_ADDC)      c_in = carry_i;
      else if (op_i == OP_SUBB) c_in = ~carry_i;
      else                      c_in = is_sub;
      {c_top, sum_o} = {1'b0, dst_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_in};
      c_into = dst_i ^ b_eff ^ sum_o;
      c_out  = {c_top, c_into[WIDTH-1:1]};
      case (size_i)
         SZ_BYTE: begin msb = IDX_W'(7);  hb = IDX_W'(3);  size_mask = WIDTH'(32'h0000_00FF); end
         SZ_WORD: begin msb = IDX_W'(15); hb = IDX_W'(11); size_mask = WIDTH'(32'h0000_FFFF); end
         default: begin msb = IDX_W'(WIDTH-1); hb = IDX_W'(WIDTH-5); size_mask = '1; end
      endcase
      flags_o        = '0;
      flags_o[FLG_C] = c_out[msb] ^ is_sub;
      flags_o[FLG_H] = c_out[hb] ^ is_sub;
      flags_o[FLG_V] = c_out[msb] ^ c_into[msb];
      flags_o[FLG_N] = sum_o[msb];
      flags_o[FLG_Z] = ((sum_o & size_mask) == '0);
   end
endmodule

// File: rtl/arith_bcd_adjust.sv
module arith_bcd_adjust
   import arith_pkg::*;
(
   input  logic              after_sub_i,
   input  logic [7:0]        val_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [7:0]        val_o,
   output logic [FLAG_W-1:0] flags_o
);
   logic       lo_big, fix_lo, fix_hi, c_new;
   logic [7:0] corr;

   always_comb begin
      lo_big = (val_i[3:0] > 4'd9);
      fix_lo = flags_i[FLG_H] | lo_big;
      fix_hi = flags_i[FLG_C] | (val_i[7:4] > 4'd9) | ((val_i[7:4] == 4'd9) & lo_big);
      if (after_sub_i) begin
         corr  = (flags_i[FLG_H] ? 8'hFA : 8'h00) + (flags_i[FLG_C] ? 8'hA0 : 8'h00);
         c_new = flags_i[FLG_C];
      end else begin
         corr  = {fix_hi ? 4'h6 : 4'h0, fix_lo ? 4'h6 : 4'h0};
         c_new = fix_hi;
      end
      val_o          = val_i + corr;
      flags_o        = '0;
      flags_o[FLG_C] = c_new;
      flags_o[FLG_V] = 1'b0;
      flags_o[FLG_H] = flags_i[FLG_H];
      flags_o[FLG_N] = val_o[7];
      flags_o[FLG_Z] = (val_o == 8'h00);
   end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
   import arith_pkg::*;
#(
   parameter int unsigned WIDTH = DATA_W
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [1:0]        size_i,
   input  logic              src_imm_i,
   input  logic [1:0]        step_i,
   input  logic [WIDTH-1:0]  dst_i,
   input  logic [WIDTH-1:0]  src_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [WIDTH-1:0]  result_o,
   output logic [FLAG_W-1:0] flags_o,
   output logic              illegal_o
);
   localparam int unsigned LANES = WIDTH / 8;

   generate
      if (WIDTH != 32 || (WIDTH % 8) != 0) begin : g_width_chk
         $error("arith_unit: WIDTH must be 32");
      end
   endgenerate

   logic              bad;
   logic [WIDTH-1:0]  sum;
   logic [FLAG_W-1:0] add_flags, bcd_flags;
   logic [7:0]        bcd_val;
   logic [WIDTH-1:0]  raw;
   logic [LANES-1:0]  lane_live;
   logic [WIDTH-1:0]  merged;
   logic              is_bcd, is_const;

   arith_legal u_legal (
      .op_i(op_i), .size_i(size_i), .src_imm_i(src_imm_i), .step_i(step_i), .illegal_o(bad)
   );

   arith_adder #(.WIDTH(WIDTH)) u_adder (
      .op_i(op_i), .size_i(size_i), .step_i(step_i), .dst_i(dst_i), .src_i(src_i),
      .carry_i(flags_i[FLG_C]), .sum_o(sum), .flags_o(add_flags)
   );

   arith_bcd_adjust u_bcd (
      .after_sub_i(op_i == OP_DADJS), .val_i(dst_i[7:0]), .flags_i(flags_i),
      .val_o(bcd_val), .flags_o(bcd_flags)
   );

   always_comb begin
      is_bcd    = (op_i == OP_DADJA) || (op_i == OP_DADJS);
      is_const  = (op_i == OP_ADDK) || (op_i == OP_SUBK);
      raw       = is_bcd ? {{(WIDTH-8){1'b0}}, bcd_val} : sum;
      case (size_i)
         SZ_BYTE: lane_live = LANES'(1);
         SZ_WORD: lane_live = LANES'(3);
         default: lane_live = '1;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*8 +: 8] = lane_live[g] ? raw[g*8 +: 8] : dst_i[g*8 +: 8];
   end

   always_comb begin
      illegal_o = bad;
      if (bad) begin
         result_o = dst_i;
         flags_o  = flags_i;
      end else begin
         result_o = merged;
         if (is_bcd)        flags_o = bcd_flags;
         else if (is_const) flags_o = flags_i;
         else               flags_o = add_flags;
      end
   end

   always_comb begin
      if (illegal_o)
         AST_ILLEGAL_HOLDS: assert (result_o == dst_i && flags_o == flags_i) else $error("illegal op changed state"); // R2
      if (!illegal_o && size_i == SZ_BYTE)
         AST_UPPER_PASS: assert (result_o[WIDTH-1:8] == dst_i[WIDTH-1:8]) else $error("upper bits altered"); // R8
      if (!illegal_o && is_const)
         AST_CONST_FLAGS: assert (flags_o == flags_i) else $error("constant op changed flags"); // R5
      if (!illegal_o && op_i == OP_DADJS)
         AST_DAS_CARRY: assert (flags_o[FLG_C] == flags_i[FLG_C] && !flags_o[FLG_V]) else $error("adjust carry"); // R7
      if (!illegal_o && !is_const && size_i == SZ_BYTE)
         AST_ZERO_FLAG: assert (flags_o[FLG_Z] == (result_o[7:0] == 8'h00)) else $error("zero flag"); // R1
      if (size_i == SZ_RSVD)
         AST_SIZE_RSVD: assert (illegal_o) else $error("reserved size accepted"); // R10
   end
endmodule

// File: tb/arith_unit_bench.sv
module arith_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op;
   logic [1:0]  size;
   logic        imm;
   logic [1:0]  step;
   logic [31:0] dst, src;
   logic [4:0]  fin;
   logic [31:0] result;
   logic [4:0]  fout;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   arith_unit u_arith_unit (
      .op_i(op), .size_i(size), .src_imm_i(imm), .step_i(step),
      .dst_i(dst), .src_i(src), .flags_i(fin),
      .result_o(result), .flags_o(fout), .illegal_o(illegal)
   );

   function automatic logic model_illegal(input logic [3:0] o, input logic [1:0] s,
                                          input logic im, input logic [1:0] st);
      if (s == 2'd3 || o > 4'd9) return 1'b1;
      if (o == 4'd1 && s == 2'd0 && im) return 1'b1;
      if ((o == 4'd2 || o == 4'd3) && s != 2'd0) return 1'b1;
      if ((o == 4'd4 || o == 4'd5) && (st > 2'd1 || (s == 2'd0 && st != 2'd0))) return 1'b1;
      if ((o == 4'd6 || o == 4'd7) && (s != 2'd2 || st == 2'd3)) return 1'b1;
      if ((o == 4'd8 || o == 4'd9) && s != 2'd0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic string tag_of(input logic [3:0] o, input logic ill);
      if (o > 4'd9) return "R10";
      if (ill) return "R2";
      case (o)
         4'd0, 4'd1: return "R1";
         4'd2, 4'd3: return "R3";
         4'd4, 4'd5: return "R4";
         4'd6, 4'd7: return "R5";
         4'd8:       return "R6";
         default:    return "R7";
      endcase
   endfunction

   task automatic model(output logic [31:0] r, output logic [4:0] f, output logic ill);
      longint w, mask, hm, a, b, ci, full, res;
      bit sub;
      int corr;
      logic [7:0] r8;
      ill = model_illegal(op, size, imm, step);
      r = dst; f = fin;
      if (ill) return;
      if (op == 4'd8 || op == 4'd9) begin
         corr = 0;
         if (op == 4'd8) begin
            if (fin[4] || dst[3:0] > 4'd9) corr += 6;
            if (fin[0] || dst[7:0] > 8'h99) begin corr += 'h60; f[0] = 1'b1; end
            else f[0] = 1'b0;
         end else begin
            if (fin[4]) corr += 'hFA;
            if (fin[0]) corr += 'hA0;
         end
         r8 = 8'(int'(dst[7:0]) + corr);
         r = {dst[31:8], r8};
         f[3] = r8[7]; f[2] = (r8 == 0); f[1] = 1'b0;
         return;
      end
      w    = (size == 2'd0) ? 8 : (size == 2'd1) ? 16 : 32;
      mask = (64'sd1 <<< w) - 1;
      hm   = (64'sd1 <<< (w - 4)) - 1;
      a    = longint'(dst) & mask;
      sub  = (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd7);
      b    = (op >= 4'd4) ? (64'sd1 <<< step) : (longint'(src) & mask);
      ci   = (op == 4'd2 || op == 4'd3) ? longint'(fin[0]) : 0;
      if (sub) begin
         full = a - b - ci;
         res  = full & mask;
         f[0] = (a < b + ci);
         f[4] = ((a & hm) < (b & hm) + ci);
         f[1] = (((a >>> (w-1)) & 1) != ((b >>> (w-1)) & 1)) && (((res >>> (w-1)) & 1) != ((a >>> (w-1)) & 1));
      end else begin
         full = a + b + ci;
         res  = full & mask;
         f[0] = ((full >>> w) & 1) != 0;
         f[4] = ((a & hm) + (b & hm) + ci) > hm;
         f[1] = (((a >>> (w-1)) & 1) == ((b >>> (w-1)) & 1)) && (((res >>> (w-1)) & 1) != ((a >>> (w-1)) & 1));
      end
      f[3] = ((res >>> (w-1)) & 1) != 0;
      f[2] = (res == 0);
      r = (dst & ~32'(mask)) | 32'(res);
      if (op == 4'd6 || op == 4'd7) f = fin;
   endtask

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (op=%0d size=%0d imm=%0d step=%0d dst=%h src=%h fl=%b)",
                  tag, what, act, exp, op, size, imm, step, dst, src, fin);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [1:0] s, input logic im, input logic [1:0] st,
                        input logic [31:0] d, input logic [31:0] sr, input logic [4:0] fl);
      logic [31:0] er; logic [4:0] ef; logic ei; string t;
      @(negedge clk);
      op = o; size = s; imm = im; step = st; dst = d; src = sr; fin = fl;
      #1;
      model(er, ef, ei);
      t = tag_of(o, ei);
      check(t, "result", result, er);
      check(t, "flags", {27'd0, fout}, {27'd0, ef});
      check(t, "illegal", {31'd0, illegal}, {31'd0, ei});
      if (!ei && s != 2'd2) check("R8", "upper", result & ~((s == 2'd0) ? 32'hFF : 32'hFFFF), d & ~((s == 2'd0) ? 32'hFF : 32'hFFFF));
      if (!ei && o < 4'd6) check("R9", "half-carry", {31'd0, fout[4]}, {31'd0, ef[4]});
   endtask

   initial begin
      #150000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      op = 0; size = 0; imm = 0; step = 0; dst = 0; src = 0; fin = 0;
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "idle result", result, 32'h0);
      check("R1", "idle flags", {27'd0, fout}, 32'h4);
      // directed corners
      apply(4'd1, 2'd0, 1'b1, 2'd0, 32'h1234_5678, 32'h1, 5'b10101);   // R2 byte sub imm
      apply(4'd1, 2'd0, 1'b0, 2'd0, 32'hAABB_0010, 32'h11, 5'b0);      // R1 borrow
      apply(4'd0, 2'd2, 1'b0, 2'd0, 32'h7FFF_FFFF, 32'h1, 5'b0);       // R1 overflow
      apply(4'd0, 2'd1, 1'b1, 2'd0, 32'hFFFF_0800, 32'h0800, 5'b0);    // R9 word bit 11
      apply(4'd2, 2'd0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0, 5'b00001);   // R3 carry in
      apply(4'd3, 2'd0, 1'b0, 2'd0, 32'h0000_0000, 32'h0, 5'b00001);   // R3 borrow in
      apply(4'd2, 2'd1, 1'b0, 2'd0, 32'h1, 32'h1, 5'b0);               // R3 word illegal
      apply(4'd4, 2'd0, 1'b0, 2'd1, 32'h5, 32'h0, 5'b0);               // R4 byte step2 illegal
      apply(4'd5, 2'd1, 1'b0, 2'd1, 32'hFFFF_0001, 32'h0, 5'b0);       // R4 word dec 2
      apply(4'd6, 2'd1, 1'b0, 2'd2, 32'h10, 32'h0, 5'b0);              // R5 word illegal
      apply(4'd7, 2'd2, 1'b0, 2'd2, 32'h0000_0002, 32'h0, 5'b01010);   // R5 flags kept
      apply(4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_009A, 32'h0, 5'b0);       // R6 both fixes
      apply(4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_0042, 32'h0, 5'b10000);   // R6 half-carry
      apply(4'd9, 2'd0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0, 5'b10001);   // R7
      apply(4'd12, 2'd0, 1'b0, 2'd0, 32'h3, 32'h3, 5'b0);              // R10
      apply(4'd0, 2'd3, 1'b0, 2'd0, 32'h3, 32'h3, 5'b0);               // R10
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] ro; logic [1:0] rs;
         ro = 4'($urandom % 11);
         rs = 2'($urandom % 4);
         apply(ro, rs, 1'($urandom), 2'($urandom), $urandom, $urandom, 5'($urandom));
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule